// File: doc/BRIEF.md
# Serial Receive and Idle-Line Interrupt Requester

This block turns the status flags of a serial receiver into interrupt requests for an interrupt controller. It watches the receive-data-full flag, the three receive error flags (parity, framing, overrun) and the idle-line status. It holds three interrupt enables, loaded through a simple write strobe. From these it drives three request lines: a normal receive request, a receive-with-exception request, and an idle-line request.

The two receive requests are combinational functions of the flags and the enables. They never appear together: when an error is flagged and exception interrupts are enabled, only the exception request is raised. The idle request is a latched flag. It sets on the rising edge of idle-line status, but only when an idle interrupt is armed and enabled. It stays set until the controller acknowledges it or software clears the idle enable. Once an idle request has been taken, no further idle request can occur until a character has been received. A character is marked by a rising edge of receive-data-full, and that edge re-arms the latch. As a result, an idle period yields at most one idle interrupt. The block also passes the live idle-line status through unchanged.

The asynchronous active-low reset is released synchronously inside the block, so the registers leave reset a fixed number of clock edges after the reset input goes high.

Top module: `rxirq_requester`

## Requirements
- R1: `rx_req_o` is high exactly when the receive enable is set, `rx_full_i` is high and `rx_exc_req_o` is low.
- R2: `rx_exc_req_o` is high exactly when the exception enable is set and at least one of `par_err_i`, `frm_err_i`, `ovr_err_i` is high.
- R3: `rx_req_o` and `rx_exc_req_o` are never high together; when both conditions hold, only the exception request is driven.
- R4: A clock edge with `en_wr_i` high loads the enables: `en_rx_i` is the receive enable, `en_exc_i` the exception enable and `en_idle_i` the idle enable. Reset clears all three, so no request is raised after reset until enables are written.
- R5: When the idle latch is armed and the idle enable is set, a rising edge of `line_idle_i` sets `idle_req_o` at the next clock edge, and it stays high while neither acknowledge nor enable clear occurs.
- R6: A clock edge with `idle_ack_i` high clears `idle_req_o`.
- R7: After an idle request has been raised, the line staying idle, or falling and rising again, raises no further idle request unless a character has been received in between.
- R8: A rising edge of `rx_full_i` re-arms the idle latch, so the next rising edge of `line_idle_i` raises `idle_req_o` again. The latch is armed out of reset.
- R9: `idle_stat_o` equals `line_idle_i` at all times.
- R10: Clearing the idle enable drops a pending `idle_req_o` at the clock edge after the enable register changes.
- R11: A rising edge of `line_idle_i` while the idle enable is clear raises no request and does not use up the arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_wr_i | input | 1 | Load strobe for the enable register |
| en_rx_i | input | 1 | Receive interrupt enable value to load |
| en_exc_i | input | 1 | Receive-exception interrupt enable value to load |
| en_idle_i | input | 1 | Idle-line interrupt enable value to load |
| rx_full_i | input | 1 | Receive-data-full flag |
| par_err_i | input | 1 | Parity error flag |
| frm_err_i | input | 1 | Framing error flag |
| ovr_err_i | input | 1 | Overrun flag |
| line_idle_i | input | 1 | Idle-line status from the receiver |
| idle_ack_i | input | 1 | Idle interrupt acknowledge from the controller |
| rx_req_o | output | 1 | Normal receive interrupt request |
| rx_exc_req_o | output | 1 | Receive-with-exception interrupt request |
| idle_req_o | output | 1 | Idle-line interrupt request |
| idle_stat_o | output | 1 | Live idle-line status |

## Verification
The bench raises a data-full flag and an error flag together, with both enables set. A design that got the priority wrong would assert both request lines, or the normal one alone. It holds the line idle after an acknowledge, and it toggles the line without a character in between. A design that re-armed on every idle edge would then raise a second idle request. The bench also clears the idle enable while a request is pending, and it shows an idle edge with the enable off. A design that ignored the enable clear would keep the request high. A design that disarmed on an unenabled edge would miss the next legitimate idle interrupt.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;

  typedef struct packed {
    logic rx;
    logic exc;
    logic idle;
  } irq_en_t;

  localparam irq_en_t IRQ_EN_RESET = '{rx: 1'b0, exc: 1'b0, idle: 1'b0};

endpackage

// File: rtl/rxirq_rst_sync.sv
module rxirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/rxirq_en_reg.sv
module rxirq_en_reg
  import rxirq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  irq_en_t en_d,
  output irq_en_t en_q
);

  irq_en_t en_nxt;

  always_comb begin
    en_nxt = en_q;
    if (wr) en_nxt = en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= IRQ_EN_RESET;
    else        en_q <= en_nxt;
  end

endmodule

// File: rtl/rxirq_rx_arb.sv
module rxirq_rx_arb
  import rxirq_pkg::*;
(
  input  irq_en_t en,
  input  logic    full,
  input  logic    par_err,
  input  logic    frm_err,
  input  logic    ovr_err,
  output logic    rx_req,
  output logic    exc_req
);

  logic any_err;

  always_comb begin
    any_err = par_err | frm_err | ovr_err;
    exc_req = en.exc & any_err;
    rx_req  = en.rx & full & ~exc_req;
  end

endmodule

// File: rtl/rxirq_idle_latch.sv
module rxirq_idle_latch #(
  parameter bit LINE_IDLE_AT_RESET = 1'b1,
  parameter bit ARMED_AT_RESET     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_en,
  input  logic line_idle,
  input  logic full,
  input  logic ack,
  output logic req,
  output logic armed
);

  logic idle_q, full_q, armed_q, pend_q;
  logic idle_nxt, full_nxt, armed_nxt, pend_nxt;
  logic idle_rise, full_rise, set_req;

  always_comb begin
    idle_rise = line_idle & ~idle_q;
    full_rise = full & ~full_q;
    set_req   = idle_rise & armed_q & idle_en;

    idle_nxt  = line_idle;
    full_nxt  = full;

    armed_nxt = armed_q;
    if (set_req)   armed_nxt = 1'b0;
    if (full_rise) armed_nxt = 1'b1;

    pend_nxt = pend_q;
    if (ack)     pend_nxt = 1'b0;
    if (set_req) pend_nxt = 1'b1;
    if (!idle_en) pend_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= LINE_IDLE_AT_RESET;
      full_q  <= 1'b0;
      armed_q <= ARMED_AT_RESET;
      pend_q  <= 1'b0;
    end else begin
      idle_q  <= idle_nxt;
      full_q  <= full_nxt;
      armed_q <= armed_nxt;
      pend_q  <= pend_nxt;
    end
  end

  assign req   = pend_q;
  assign armed = armed_q;

endmodule

// File: rtl/rxirq_requester.sv
module rxirq_requester
  import rxirq_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr_i,
  input  logic en_rx_i,
  input  logic en_exc_i,
  input  logic en_idle_i,
  input  logic rx_full_i,
  input  logic par_err_i,
  input  logic frm_err_i,
  input  logic ovr_err_i,
  input  logic line_idle_i,
  input  logic idle_ack_i,
  output logic rx_req_o,
  output logic rx_exc_req_o,
  output logic idle_req_o,
  output logic idle_stat_o
);

  logic    rst_sn;
  irq_en_t en_d;
  irq_en_t en_q;
  logic    idle_armed;

  assign en_d = '{rx: en_rx_i, exc: en_exc_i, idle: en_idle_i};

  rxirq_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  rxirq_en_reg u_en (
    .clk   (clk),
    .rst_n (rst_sn),
    .wr    (en_wr_i),
    .en_d  (en_d),
    .en_q  (en_q)
  );

  rxirq_rx_arb u_arb (
    .en      (en_q),
    .full    (rx_full_i),
    .par_err (par_err_i),
    .frm_err (frm_err_i),
    .ovr_err (ovr_err_i),
    .rx_req  (rx_req_o),
    .exc_req (rx_exc_req_o)
  );

  rxirq_idle_latch u_idle (
    .clk       (clk),
    .rst_n     (rst_sn),
    .idle_en   (en_q.idle),
    .line_idle (line_idle_i),
    .full      (rx_full_i),
    .ack       (idle_ack_i),
    .req       (idle_req_o),
    .armed     (idle_armed)
  );

  assign idle_stat_o = line_idle_i;

endmodule

// File: rtl/rxirq_requester_chk.sv
module rxirq_requester_chk (
  input logic clk,
  input logic rst_sn,
  input logic en_idle,
  input logic armed,
  input logic rx_full_i,
  input logic par_err_i,
  input logic frm_err_i,
  input logic ovr_err_i,
  input logic idle_ack_i,
  input logic rx_req_o,
  input logic rx_exc_req_o,
  input logic idle_req_o
);

  AST_RX_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_req_o |-> rx_full_i); // R1

  AST_EXC_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_sn)
    rx_exc_req_o |-> (par_err_i | frm_err_i | ovr_err_i)); // R2

  AST_RX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sn)
    !(rx_req_o && rx_exc_req_o)); // R3

  AST_IDLE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    (idle_req_o && idle_ack_i && !armed) |=> !idle_req_o); // R6

  AST_IDLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(idle_req_o) |-> $past(armed)); // R7

  AST_IDLE_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_sn)
    !en_idle |=> !idle_req_o); // R10

endmodule

bind rxirq_requester rxirq_requester_chk chk_i (
  .clk          (clk),
  .rst_sn       (rst_sn),
  .en_idle      (en_q.idle),
  .armed        (idle_armed),
  .rx_full_i    (rx_full_i),
  .par_err_i    (par_err_i),
  .frm_err_i    (frm_err_i),
  .ovr_err_i    (ovr_err_i),
  .idle_ack_i   (idle_ack_i),
  .rx_req_o     (rx_req_o),
  .rx_exc_req_o (rx_exc_req_o),
  .idle_req_o   (idle_req_o)
);

// File: tb/rxirq_requester_tb_top.sv
module rxirq_requester_tb_top;

  logic clk;
  logic rst_n;
  logic en_wr_i, en_rx_i, en_exc_i, en_idle_i;
  logic rx_full_i, par_err_i, frm_err_i, ovr_err_i;
  logic line_idle_i, idle_ack_i;
  logic rx_req_o, rx_exc_req_o, idle_req_o, idle_stat_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  rxirq_requester dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_wr_i      (en_wr_i),
    .en_rx_i      (en_rx_i),
    .en_exc_i     (en_exc_i),
    .en_idle_i    (en_idle_i),
    .rx_full_i    (rx_full_i),
    .par_err_i    (par_err_i),
    .frm_err_i    (frm_err_i),
    .ovr_err_i    (ovr_err_i),
    .line_idle_i  (line_idle_i),
    .idle_ack_i   (idle_ack_i),
    .rx_req_o     (rx_req_o),
    .rx_exc_req_o (rx_exc_req_o),
    .idle_req_o   (idle_req_o),
    .idle_stat_o  (idle_stat_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_en(input logic rx, input logic exc, input logic idle);
    en_rx_i = rx; en_exc_i = exc; en_idle_i = idle; en_wr_i = 1'b1;
    step();
    en_wr_i = 1'b0;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    en_wr_i = 0; en_rx_i = 0; en_exc_i = 0; en_idle_i = 0;
    rx_full_i = 0; par_err_i = 0; frm_err_i = 0; ovr_err_i = 0;
    line_idle_i = 0; idle_ack_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic t_reset();
    apply_reset();
    write_en(1, 1, 1);
    apply_reset();
    rx_full_i = 1; par_err_i = 1;
    #1;
    check("R4 rx_req after reset", rx_req_o, 1'b0);
    check("R4 exc_req after reset", rx_exc_req_o, 1'b0);
    check("R4 idle_req after reset", idle_req_o, 1'b0);
    line_idle_i = 1;
    step();
    check("R4 idle disabled after reset", idle_req_o, 1'b0);
  endtask

  task automatic t_rx_normal();
    apply_reset();
    write_en(1, 0, 0);
    check("R1 no full no req", rx_req_o, 1'b0);
    rx_full_i = 1; #1;
    check("R1 full raises rx_req", rx_req_o, 1'b1);
    frm_err_i = 1; #1;
    check("R2 exc disabled no exc_req", rx_exc_req_o, 1'b0);
    check("R1 err without exc enable keeps rx_req", rx_req_o, 1'b1);
    frm_err_i = 0; rx_full_i = 0; #1;
    check("R1 full cleared", rx_req_o, 1'b0);
  endtask

  task automatic t_exc_priority();
    apply_reset();
    write_en(1, 1, 0);
    rx_full_i = 1; par_err_i = 1; #1;
    check("R3 exc wins rx_req", rx_req_o, 1'b0);
    check("R3 exc wins exc_req", rx_exc_req_o, 1'b1);
    par_err_i = 0; ovr_err_i = 1; #1;
    check("R2 overrun exc_req", rx_exc_req_o, 1'b1);
    ovr_err_i = 0; frm_err_i = 1; rx_full_i = 0; #1;
    check("R2 framing exc_req without full", rx_exc_req_o, 1'b1);
    frm_err_i = 0; rx_full_i = 1; #1;
    check("R3 errors clear gives rx_req", rx_req_o, 1'b1);
    check("R2 errors clear drops exc_req", rx_exc_req_o, 1'b0);
  endtask

  task automatic t_idle_basic();
    apply_reset();
    write_en(0, 0, 1);
    line_idle_i = 1; #1;
    check("R9 status follows line high", idle_stat_o, 1'b1);
    check("R5 not before edge", idle_req_o, 1'b0);
    step();
    check("R5 idle_req set", idle_req_o, 1'b1);
    repeat (3) step();
    check("R5 idle_req held", idle_req_o, 1'b1);
    idle_ack_i = 1;
    step();
    idle_ack_i = 0;
    check("R6 ack clears", idle_req_o, 1'b0);
    line_idle_i = 0; #1;
    check("R9 status follows line low", idle_stat_o, 1'b0);
  endtask

  task automatic t_idle_once();
    apply_reset();
    write_en(0, 0, 1);
    line_idle_i = 1; step();
    idle_ack_i = 1; step(); idle_ack_i = 0;
    repeat (5) step();
    check("R7 long idle no repeat", idle_req_o, 1'b0);
    line_idle_i = 0; step();
    line_idle_i = 1; step(); step();
    check("R7 idle toggle without char", idle_req_o, 1'b0);
  endtask

  task automatic t_rearm();
    apply_reset();
    write_en(0, 0, 1);
    line_idle_i = 1; step();
    idle_ack_i = 1; step(); idle_ack_i = 0;
    line_idle_i = 0;
    rx_full_i = 1; step();
    rx_full_i = 0; step();
    line_idle_i = 1; step();
    check("R8 rearmed by char", idle_req_o, 1'b1);
  endtask

  task automatic t_idle_disable();
    apply_reset();
    write_en(0, 0, 1);
    line_idle_i = 1; step();
    check("R10 pending before disable", idle_req_o, 1'b1);
    write_en(0, 0, 0);
    step();
    check("R10 disable drops request", idle_req_o, 1'b0);
    write_en(0, 0, 1);
    step();
    check("R10 stays low after reenable", idle_req_o, 1'b0);
  endtask

  task automatic t_no_consume();
    apply_reset();
    line_idle_i = 1; step();
    check("R11 no req while disabled", idle_req_o, 1'b0);
    line_idle_i = 0; step();
    write_en(0, 0, 1);
    line_idle_i = 1; step();
    check("R11 arming kept", idle_req_o, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rx_normal();
    t_exc_priority();
    t_idle_basic();
    t_idle_once();
    t_rearm();
    t_idle_disable();
    t_no_consume();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule